// File: doc/BRIEF.md
# Segmented Result Unload Serializer

This block takes the result of one lookup-engine operation, an 80-bit entry split at a programmable point into a key part (the low bits) and a data part (the remaining high bits). It sends that result out on a narrow output port as a series of words, one per clock. The port carries either 32-bit or 16-bit words, chosen with each result. The operation type sets which parts are sent. A queue read sends the key words and then the data words. A search sends only the data words.

Each part is moved down to bit 0 before it is split. Its least significant word goes out first. When a part's width is not a whole number of words, the unused high bits of its last word are zero. The port has no ready signal. Every word is shown for exactly one cycle with a valid pulse and is replaced by the next word. A consumer may stop taking words at any time. If a new result is captured while words are still going out, the remaining old words are dropped and the new result starts from its first word.

Top module: `result_unload_serializer`

## Requirements
- R1: While `rstN` is low, and right after it rises, `outValid` is 0 and `outWord` is 0.
- R2: For a queue read (`resOp`=1), the key words go out in consecutive cycles. The data words follow right after them. The total is ceil(k/W) + ceil((80-k)/W), where k is the effective key width and W is the word width.
- R3: For a search (`resOp`=0), only the ceil((80-k)/W) data words go out. No key word is sent.
- R4: The key part is entry bits [k-1:0]. The data part is entry bits [79:k], moved down to bit 0. Word i of a part carries part bits [i*W +: W].
- R5: Part bits above the part's width read as zero in the last word. In 16-bit mode, `outWord[31:16]` is always zero.
- R6: `wideSel`=1 selects 32-bit words and `wideSel`=0 selects 16-bit words. The value is captured with the result.
- R7: A result is captured on the rising edge where `resValid` is high. No word is valid in the cycle after that edge. The first word appears one edge later, and `outValid` is high for exactly one cycle per word and never otherwise.
- R8: A result captured while words are still pending drops the rest of the old result. The next word sent is word 0 of the new result.
- R9: `camBits` gives k. A value of 0 means no key words. A value of 80 or more is treated as 80, which means no data words, so a search sends nothing.
- R10: When `outValid` is low, `outWord` keeps the last word sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | Capture a new result on this edge |
| resOp | input | 1 | Operation: 1 queue read, 0 search |
| resEntry | input | 80 | Result entry, key in the low bits |
| camBits | input | 7 | Key-part width k in bits (clamped to 80) |
| wideSel | input | 1 | 1 selects 32-bit words, 0 selects 16-bit words |
| outWord | output | 32 | Current output word |
| outValid | output | 1 | One-cycle strobe for each new word |

## Verification
The scoreboard is tried with both operation types in both port widths. It uses key widths that fall on a word boundary and widths that do not, so a bad part split or bad right alignment shows up as a wrong word, and a missing zero fill shows up in the upper bits. Key widths of 0, 80 and an out-of-range 100 check that an empty part sends no word and that the clamp works. A second result issued after one word of a three-word run checks that the old words are dropped and that the new run starts from its own first word. Idle cycles after each run catch extra strobes and check that the last word is held.

// File: rtl/unload_pkg.sv
package unload_pkg;

  typedef enum logic {
    OP_SEARCH = 1'b0,
    OP_QREAD  = 1'b1
  } opKind_e;

  typedef struct packed {
    logic load;
    logic emitCam;
    logic emitRam;
  } seqStrobe_t;

endpackage

// File: rtl/unload_control.sv
module unload_control
  import unload_pkg::*;
#(
  parameter int ENTRY_W = 80,
  parameter int PORT_W  = 32,
  parameter int PART_W  = $clog2(ENTRY_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic              resOp,
  input  logic [PART_W-1:0] camEff,
  input  logic              wideSel,
  output seqStrobe_t        strobe
);

  localparam int HALF_W = PORT_W / 2;
  localparam int CNT_W  = $clog2(ENTRY_W / HALF_W + 2);

  logic [CNT_W-1:0] camLeft, ramLeft;
  logic [CNT_W-1:0] camWordsNew, ramWordsNew;

  function automatic logic [CNT_W-1:0] wordsFor(input int bits, input logic wide);
    int w;
    w = wide ? PORT_W : HALF_W;
    return CNT_W'((bits + w - 1) / w);
  endfunction

  always_comb begin
    camWordsNew = wordsFor(int'(camEff), wideSel);
    ramWordsNew = wordsFor(ENTRY_W - int'(camEff), wideSel);
  end

  always_comb begin
    strobe.load    = resValid;
    strobe.emitCam = !resValid && (camLeft != '0);
    strobe.emitRam = !resValid && (camLeft == '0) && (ramLeft != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      camLeft <= '0;
      ramLeft <= '0;
    end else if (strobe.load) begin
      camLeft <= (opKind_e'(resOp) == OP_QREAD) ? camWordsNew : '0;
      ramLeft <= ramWordsNew;
    end else if (strobe.emitCam) begin
      camLeft <= camLeft - 1'b1;
    end else if (strobe.emitRam) begin
      ramLeft <= ramLeft - 1'b1;
    end
  end

  // R3
  search_no_cam_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && opKind_e'(resOp) == OP_SEARCH) |=> (camLeft == '0));

  // R2
  ram_after_cam_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emitCam && camLeft == CNT_W'(1) && ramLeft != '0)
      |=> (strobe.emitRam || strobe.load));

endmodule

// File: rtl/unload_datapath.sv
module unload_datapath
  import unload_pkg::*;
#(
  parameter int ENTRY_W = 80,
  parameter int PORT_W  = 32,
  parameter int PART_W  = $clog2(ENTRY_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [ENTRY_W-1:0] resEntry,
  input  logic [PART_W-1:0]  camEff,
  input  logic               wideSel,
  output logic [PORT_W-1:0]  outWord,
  output logic               outValid
);

  localparam int HALF_W = PORT_W / 2;

  logic [ENTRY_W-1:0] camQ, ramQ, camMask;
  logic               wideQ;
  logic [ENTRY_W-1:0] srcPart;
  logic [PORT_W-1:0]  pickWord;

  always_comb begin
    if (int'(camEff) >= ENTRY_W) camMask = {ENTRY_W{1'b1}};
    else                         camMask = (ENTRY_W'(1) << camEff) - ENTRY_W'(1);
  end

  always_comb begin
    srcPart  = strobe.emitCam ? camQ : ramQ;
    pickWord = wideQ ? srcPart[PORT_W-1:0]
                     : {{(PORT_W-HALF_W){1'b0}}, srcPart[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      camQ     <= '0;
      ramQ     <= '0;
      wideQ    <= 1'b1;
      outWord  <= '0;
      outValid <= 1'b0;
    end else if (strobe.load) begin
      camQ     <= resEntry & camMask;
      ramQ     <= resEntry >> camEff;
      wideQ    <= wideSel;
      outValid <= 1'b0;
    end else if (strobe.emitCam || strobe.emitRam) begin
      outWord  <= pickWord;
      outValid <= 1'b1;
      if (strobe.emitCam) camQ <= wideQ ? (camQ >> PORT_W) : (camQ >> HALF_W);
      else                ramQ <= wideQ ? (ramQ >> PORT_W) : (ramQ >> HALF_W);
    end else begin
      outValid <= 1'b0;
    end
  end

  // R10
  hold_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outWord));

  // R5
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !wideQ) |-> (outWord[PORT_W-1:HALF_W] == '0));

  // R7
  load_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !outValid);

endmodule

// File: rtl/result_unload_serializer.sv
module result_unload_serializer
  import unload_pkg::*;
#(
  parameter int ENTRY_W = 80,
  parameter int PORT_W  = 32,
  parameter int PART_W  = $clog2(ENTRY_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resValid,
  input  logic               resOp,
  input  logic [ENTRY_W-1:0] resEntry,
  input  logic [PART_W-1:0]  camBits,
  input  logic               wideSel,
  output logic [PORT_W-1:0]  outWord,
  output logic               outValid
);

  seqStrobe_t        strobe;
  logic [PART_W-1:0] camEff;

  // R9: out-of-range partition widths clamp to the full entry
  assign camEff = (int'(camBits) > ENTRY_W) ? PART_W'(ENTRY_W) : camBits;

  unload_control #(.ENTRY_W(ENTRY_W), .PORT_W(PORT_W), .PART_W(PART_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resOp(resOp),
    .camEff(camEff), .wideSel(wideSel), .strobe(strobe)
  );

  unload_datapath #(.ENTRY_W(ENTRY_W), .PORT_W(PORT_W), .PART_W(PART_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .resEntry(resEntry),
    .camEff(camEff), .wideSel(wideSel), .outWord(outWord), .outValid(outValid)
  );

endmodule

// File: tb/test_result_unload_serializer.sv
module test_result_unload_serializer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic        resOp = 1'b0;
  logic [79:0] resEntry = '0;
  logic [6:0]  camBits = '0;
  logic        wideSel = 1'b1;
  logic [31:0] outWord;
  logic        outValid;

  int tests = 0;
  int fails = 0;
  int pending = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] lastWord = '0;

  always #4 clk = ~clk;

  result_unload_serializer i_result_unload_serializer (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resOp(resOp),
    .resEntry(resEntry), .camBits(camBits), .wideSel(wideSel),
    .outWord(outWord), .outValid(outValid)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushPart(input logic [79:0] part, input int bits, input int w, input string tag);
    int n;
    logic [79:0] sh;
    n = (bits + w - 1) / w;
    for (int i = 0; i < n; i++) begin
      sh = part >> (i * w);
      expQ.push_back((w == 32) ? sh[31:0] : {16'h0, sh[15:0]});
      tagQ.push_back(tag);
    end
  endtask

  task automatic issue(input bit op, input logic [79:0] entry, input int cb, input bit wide, input string tag);
    int k, w;
    logic [79:0] camPart, ramPart;
    k = (cb > 80) ? 80 : cb;
    w = wide ? 32 : 16;
    camPart = (k >= 80) ? entry : (entry & ((80'(1) << k) - 80'(1)));
    ramPart = entry >> k;
    @(negedge clk);
    resValid = 1'b1; resOp = op; resEntry = entry; camBits = 7'(cb); wideSel = wide;
    expQ.delete(); tagQ.delete();
    if (op) pushPart(camPart, k, w, {tag, " cam"});
    pushPart(ramPart, 80 - k, w, {tag, " ram"});
    pending = 1;
    @(negedge clk);
    resValid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (expQ.size() > 0 && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, {tag, " all words sent"}, 32'(expQ.size()), 32'd0);
    check(!outValid && outWord == lastWord, {"R10 hold ", tag}, outWord, lastWord);
  endtask

  // monitor: sample 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      if (pending > 0) begin
        check(!outValid, "R7 no word right after capture", {31'h0, outValid}, 32'd0);
        pending--;
      end else if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected word", outWord, 32'hx);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(outWord === e, t, outWord, e);
        end
        lastWord = outWord;
      end else if (expQ.size() > 0) begin
        check(1'b0, "R7 missing word", 32'd0, expQ[0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && outWord == 32'h0, "R1 reset state", outWord, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && outWord == 32'h0, "R1 after reset", outWord, 32'h0);

    issue(1'b1, 80'hA1B2_C3D4_E5F6_0718_293A, 48, 1'b1, "R2 R4 R6 qread wide k48");
    drain("R2");
    issue(1'b1, 80'hFEDC_BA98_7654_3210_0F1E, 40, 1'b0, "R2 R5 R6 qread narrow k40");
    drain("R6");
    issue(1'b0, 80'h1357_9BDF_2468_ACE0_5A5A, 36, 1'b1, "R3 R5 search wide k36");
    drain("R3");
    issue(1'b0, 80'h0F0F_F0F0_1234_8765_CAFE, 64, 1'b0, "R3 R4 search narrow k64");
    drain("R4");
    issue(1'b1, 80'h8000_0001_DEAD_BEEF_7777, 0, 1'b1, "R9 qread k0");
    drain("R9 k0");
    issue(1'b0, 80'h1111_2222_3333_4444_5555, 80, 1'b1, "R9 search k80");
    drain("R9 k80");
    issue(1'b1, 80'h9999_AAAA_BBBB_CCCC_DDDD, 100, 1'b0, "R9 qread clamp k100");
    drain("R9 clamp");
    issue(1'b1, 80'h0123_4567_89AB_CDEF_0246, 64, 1'b1, "R8 first run");
    issue(1'b0, 80'hC0DE_D00D_5555_AAAA_3C3C, 20, 1'b0, "R8 restart");
    drain("R8");
    issue(1'b1, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, 24, 1'b0, "R5 all ones k24");
    drain("R5");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule